// File: doc/BRIEF.md
# Predicated Vector Floating-Point Comparator

This block compares two 128-bit vectors of packed IEEE-754 values lane by lane and returns a byte-granular predicate. A lane can hold a half-, single- or double-precision value. One operation code selects equal, greater-or-equal, greater-than, unordered, not-equal, less-than or less-or-equal. Less-than and less-or-equal are greater-than and greater-or-equal with the two operands exchanged.

Each lane owns a group of esize/8 predicate bits. The lane takes part only when the lowest bit of its group in the governing mask is set. Its boolean result is written to that lowest bit and every other bit of the group is cleared. A lane that does not take part writes zeros to its whole group. The result is registered once per accepted input, and no condition flags are produced.

Top module: `vfp_pred_cmp`

## Requirements
- R1: While rst_ni is low, pred_o and valid_o are zero.
- R2: valid_o equals valid_i delayed by one clock. pred_o loads a new result only on a clock where valid_i is 1. Otherwise it holds its value.
- R3: esize_i selects the lane width: 01 gives 8 lanes of 16 bits, 10 gives 4 lanes of 32 bits, 11 gives 2 lanes of 64 bits. 00 gives an all-zero predicate.
- R4: Lane e is active when gov_i[e*W/8] is 1, where W is the lane width. An inactive lane writes zeros to predicate bits e*W/8 through (e+1)*W/8-1. The other gov_i bits of a group have no effect.
- R5: An active lane writes its result to bit e*W/8 and clears the remaining bits of its group.
- R6: cmp_op_i encodes 0 equal, 1 greater-or-equal, 2 greater-than, 3 unordered, 4 not-equal, 5 less-than and 6 less-or-equal. The comparison is always op_a_i against op_b_i. Code 7 yields an all-zero predicate.
- R7: A value is NaN when all its exponent bits are 1 and its fraction is non-zero. Exponent widths are 5, 8 and 11 bits for the three lane widths. When either operand is NaN, equal, greater-or-equal, greater-than, less-than and less-or-equal return 0, while not-equal and unordered return 1. Unordered returns 0 when neither operand is NaN.
- R8: Positive and negative zero compare equal, and neither is greater than the other.
- R9: Non-NaN values are ordered by their numeric value. This covers negative values and both infinities.
- R10: Less-than returns the greater-than result with the operands exchanged. Less-or-equal returns the greater-or-equal result with the operands exchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input qualifier |
| op_a_i | input | 128 | First operand vector |
| op_b_i | input | 128 | Second operand vector |
| gov_i | input | 16 | Governing predicate, one bit per byte |
| esize_i | input | 2 | Lane width select |
| cmp_op_i | input | 3 | Comparison select |
| valid_o | output | 1 | Result qualifier |
| pred_o | output | 16 | Destination predicate |

## Verification
The design has little state: the output register and its qualifier. If the qualifier is wrong, valid_o disagrees with valid_i from the previous clock. If the load enable is wrong, pred_o changes on a clock without valid input, or keeps a stale value, and this shows on the very next edge. A fault in the lane logic or the packing shows in the same cycle the result is registered. Typical signs are a set bit outside a group's lowest position, or a set bit under a cleared governing bit. The bench compares pred_o against an independent reference model on every clock. Its directed cases hit NaN, signed zero, infinity and negative ordering in each lane width.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_GE  = 3'd1,
    CMP_GT  = 3'd2,
    CMP_UN  = 3'd3,
    CMP_NE  = 3'd4,
    CMP_LT  = 3'd5,
    CMP_LE  = 3'd6,
    CMP_RSV = 3'd7
  } cmp_op_e;

  typedef enum logic [1:0] {
    ESZ_NONE = 2'd0,
    ESZ_H    = 2'd1,
    ESZ_S    = 2'd2,
    ESZ_D    = 2'd3
  } esize_e;

  function automatic int exp_width(input int ew);
    case (ew)
      16:      return 5;
      32:      return 8;
      default: return 11;
    endcase
  endfunction
endpackage

// File: rtl/vcmp_lane.sv
module vcmp_lane
  import vcmp_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  cmp_op_e       op_i,
  output logic          res_o
);
  localparam int XW = exp_width(EW);
  localparam int MW = EW - 1 - XW;

  logic a_nan, b_nan, un, zz, eq;
  logic a_mag_gt, b_mag_gt;
  logic gt_ab, gt_ba, ge_ab, ge_ba;
  logic sa, sb;

  assign sa    = a_i[EW-1];
  assign sb    = b_i[EW-1];
  assign a_nan = (&a_i[EW-2:MW]) & (|a_i[MW-1:0]);
  assign b_nan = (&b_i[EW-2:MW]) & (|b_i[MW-1:0]);
  assign un    = a_nan | b_nan;
  assign zz    = ~(|a_i[EW-2:0]) & ~(|b_i[EW-2:0]);
  assign eq    = ~un & (zz | (a_i == b_i));

  assign a_mag_gt = a_i[EW-2:0] > b_i[EW-2:0];
  assign b_mag_gt = b_i[EW-2:0] > a_i[EW-2:0];

  // sign-magnitude order; magnitude sense flips when both negative
  assign gt_ab = ~un & ~zz & ((sa != sb) ? ~sa : (sa ? b_mag_gt : a_mag_gt));
  assign gt_ba = ~un & ~zz & ((sa != sb) ? ~sb : (sa ? a_mag_gt : b_mag_gt));
  assign ge_ab = gt_ab | eq;
  assign ge_ba = gt_ba | eq;

  always_comb begin
    unique case (op_i)
      CMP_EQ:  res_o = eq;
      CMP_GE:  res_o = ge_ab;
      CMP_GT:  res_o = gt_ab;
      CMP_UN:  res_o = un;
      CMP_NE:  res_o = ~eq;
      CMP_LT:  res_o = gt_ba;
      CMP_LE:  res_o = ge_ba;
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/vcmp_size_grp.sv
module vcmp_size_grp
  import vcmp_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int EW    = 32
) (
  input  logic [VEC_W-1:0]   a_i,
  input  logic [VEC_W-1:0]   b_i,
  input  logic [VEC_W/8-1:0] gov_i,
  input  cmp_op_e            op_i,
  output logic [VEC_W/8-1:0] pred_o
);
  localparam int PRED_W = VEC_W / 8;
  localparam int LANES  = VEC_W / EW;
  localparam int GRP    = EW / 8;

  logic [LANES-1:0] lane_res;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    vcmp_lane #(.EW(EW)) u_lane (
      .a_i  (a_i[e*EW +: EW]),
      .b_i  (b_i[e*EW +: EW]),
      .op_i (op_i),
      .res_o(lane_res[e])
    );
  end

  always_comb begin
    pred_o = '0;
    for (int e = 0; e < LANES; e++) begin
      pred_o[e*GRP] = gov_i[e*GRP] & lane_res[e];
    end
  end

  logic unused_gov;
  assign unused_gov = ^gov_i[PRED_W-1:0];
endmodule

// File: rtl/vfp_pred_cmp.sv
module vfp_pred_cmp
  import vcmp_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int PRED_W = VEC_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [VEC_W-1:0]  op_a_i,
  input  logic [VEC_W-1:0]  op_b_i,
  input  logic [PRED_W-1:0] gov_i,
  input  logic [1:0]        esize_i,
  input  logic [2:0]        cmp_op_i,
  output logic              valid_o,
  output logic [PRED_W-1:0] pred_o
);
  cmp_op_e           op;
  logic [PRED_W-1:0] grp_pred [3];
  logic [PRED_W-1:0] res_d;

  assign op = cmp_op_e'(cmp_op_i);

  // one group per lane width: 16, 32, 64
  for (genvar k = 0; k < 3; k++) begin : g_size
    vcmp_size_grp #(.VEC_W(VEC_W), .EW(16 << k)) u_grp (
      .a_i   (op_a_i),
      .b_i   (op_b_i),
      .gov_i (gov_i),
      .op_i  (op),
      .pred_o(grp_pred[k])
    );
  end

  always_comb begin
    unique case (esize_e'(esize_i))
      ESZ_H:   res_d = grp_pred[0];
      ESZ_S:   res_d = grp_pred[1];
      ESZ_D:   res_d = grp_pred[2];
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pred_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) pred_o <= res_d;
    end
  end
endmodule

// File: rtl/vcmp_checker.sv
module vcmp_checker #(
  parameter int PRED_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [PRED_W-1:0] gov_i,
  input logic [1:0]        esize_i,
  input logic [2:0]        cmp_op_i,
  input logic              valid_o,
  input logic [PRED_W-1:0] pred_o
);
  logic              armed;
  logic [PRED_W-1:0] low_mask, low_mask_q, gov_q;
  logic              zero_q;

  always_comb begin
    low_mask = '0;
    for (int i = 0; i < PRED_W; i++) begin
      case (esize_i)
        2'd1:    low_mask[i] = (i % 2) == 0;
        2'd2:    low_mask[i] = (i % 4) == 0;
        2'd3:    low_mask[i] = (i % 8) == 0;
        default: low_mask[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed      <= 1'b0;
      low_mask_q <= '0;
      gov_q      <= '0;
      zero_q     <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (valid_i) begin
        low_mask_q <= low_mask;
        gov_q      <= gov_i;
        zero_q     <= (esize_i == 2'd0) || (cmp_op_i == 3'd7);
      end
    end
  end

  assert_valid_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    valid_o == $past(valid_i));

  assert_hold_no_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !$past(valid_i) |-> $stable(pred_o));

  assert_inactive_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_o & ~gov_q) == '0);

  assert_group_upper_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_o & ~low_mask_q) == '0);

  assert_invalid_sel_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_q |-> pred_o == '0);

  always_comb begin
    if (!rst_ni) assert_reset_clear_R1: assert (pred_o == '0 && !valid_o);
  end
endmodule

bind vfp_pred_cmp vcmp_checker #(.PRED_W(PRED_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .gov_i   (gov_i),
  .esize_i (esize_i),
  .cmp_op_i(cmp_op_i),
  .valid_o (valid_o),
  .pred_o  (pred_o)
);

// File: tb/tb_vfp_pred_cmp.sv
`timescale 1ns/1ps
module tb_vfp_pred_cmp;
  localparam real CLK_NS = 10.0;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] op_a_i = '0;
  logic [127:0] op_b_i = '0;
  logic [15:0]  gov_i = '0;
  logic [1:0]   esize_i = '0;
  logic [2:0]   cmp_op_i = '0;
  logic         valid_o;
  logic [15:0]  pred_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] exp_pred = '0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  vfp_pred_cmp dut (.*);

  function automatic logic [15:0] model(input logic [127:0] a, input logic [127:0] b,
                                        input logic [15:0] gov, input logic [1:0] es,
                                        input logic [2:0] op);
    int ew, xw, n;
    logic [15:0] r;
    r = '0;
    if (es == 2'd0 || op == 3'd7) return r;
    ew = (es == 2'd1) ? 16 : (es == 2'd2) ? 32 : 64;
    xw = (ew == 16) ? 5 : (ew == 32) ? 8 : 11;
    n  = 128 / ew;
    for (int e = 0; e < n; e++) begin
      logic [63:0] x, y, m;
      longint kx, ky;
      bit nx, ny, un, eq, gt, lt, res;
      m = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
      x = 64'(a >> (e*ew)) & m;
      y = 64'(b >> (e*ew)) & m;
      nx = (((x >> (ew-1-xw)) & ((64'd1 << xw) - 1)) == ((64'd1 << xw) - 1)) &&
           ((x & ((64'd1 << (ew-1-xw)) - 1)) != 0);
      ny = (((y >> (ew-1-xw)) & ((64'd1 << xw) - 1)) == ((64'd1 << xw) - 1)) &&
           ((y & ((64'd1 << (ew-1-xw)) - 1)) != 0);
      kx = longint'(x & ((64'd1 << (ew-1)) - 1));
      ky = longint'(y & ((64'd1 << (ew-1)) - 1));
      if (x[ew-1]) kx = -kx;
      if (y[ew-1]) ky = -ky;
      un = nx || ny;
      eq = !un && (kx == ky);
      gt = !un && (kx > ky);
      lt = !un && (kx < ky);
      case (op)
        3'd0: res = eq;
        3'd1: res = gt || eq;
        3'd2: res = gt;
        3'd3: res = un;
        3'd4: res = !eq;
        3'd5: res = lt;
        default: res = lt || eq;
      endcase
      if (gov[e*ew/8]) r[e*ew/8] = res;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, compare after the capturing edge
  task automatic step(input logic [127:0] a, input logic [127:0] b, input logic [15:0] gov,
                      input logic [1:0] es, input logic [2:0] op, input logic v, input string tag);
    @(negedge clk_i);
    op_a_i = a; op_b_i = b; gov_i = gov; esize_i = es; cmp_op_i = op; valid_i = v;
    if (v) exp_pred = model(a, b, gov, es, op);
    @(posedge clk_i);
    #1;
    chk({tag, " valid"}, {15'd0, valid_o}, {15'd0, v});
    chk(tag, pred_o, exp_pred);
  endtask

  function automatic logic [127:0] rep16(input logic [15:0] h);
    return {8{h}};
  endfunction
  function automatic logic [127:0] rep32(input logic [31:0] s);
    return {4{s}};
  endfunction
  function automatic logic [127:0] rep64(input logic [63:0] d);
    return {2{d}};
  endfunction

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset pred", pred_o, 16'h0000);
    chk("R1 reset valid", {15'd0, valid_o}, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R5: half lanes, 1.0 > 0.5 on every lane
    step(rep16(16'h3C00), rep16(16'h3800), 16'hFFFF, 2'd1, 3'd2, 1'b1, "R5 half gt");
    chk("R5 literal", pred_o, 16'h5555);
    // R2: no valid -> hold, valid_o low
    step(rep16(16'h3800), rep16(16'h3C00), 16'hFFFF, 2'd1, 3'd2, 1'b0, "R2 hold");
    chk("R2 hold literal", pred_o, 16'h5555);
    // R7: NaN cases
    step(rep16(16'h7E00), rep16(16'h3C00), 16'hFFFF, 2'd1, 3'd0, 1'b1, "R7 nan eq");
    chk("R7 eq literal", pred_o, 16'h0000);
    step(rep16(16'h7E00), rep16(16'h3C00), 16'hFFFF, 2'd1, 3'd2, 1'b1, "R7 nan gt");
    step(rep16(16'h3C00), rep16(16'h7C01), 16'hFFFF, 2'd1, 3'd6, 1'b1, "R7 nan le");
    step(rep16(16'h7E00), rep16(16'h3C00), 16'hFFFF, 2'd1, 3'd4, 1'b1, "R7 nan ne");
    chk("R7 ne literal", pred_o, 16'h5555);
    step(rep16(16'h7E00), rep16(16'h3C00), 16'hFFFF, 2'd1, 3'd3, 1'b1, "R7 nan un");
    step(rep16(16'h7C00), rep16(16'h3C00), 16'hFFFF, 2'd1, 3'd3, 1'b1, "R7 inf not un");
    chk("R7 inf literal", pred_o, 16'h0000);
    // R8: signed zeros
    step(rep16(16'h0000), rep16(16'h8000), 16'hFFFF, 2'd1, 3'd0, 1'b1, "R8 zero eq");
    chk("R8 eq literal", pred_o, 16'h5555);
    step(rep16(16'h0000), rep16(16'h8000), 16'hFFFF, 2'd1, 3'd2, 1'b1, "R8 zero gt");
    chk("R8 gt literal", pred_o, 16'h0000);
    step(rep32(32'h8000_0000), rep32(32'h0000_0000), 16'hFFFF, 2'd2, 3'd5, 1'b1, "R8 zero lt");
    // R9/R10: negatives and infinity
    step(rep16(16'hC000), rep16(16'hBC00), 16'hFFFF, 2'd1, 3'd2, 1'b1, "R9 neg gt");
    chk("R9 neg literal", pred_o, 16'h0000);
    step(rep16(16'hC000), rep16(16'hBC00), 16'hFFFF, 2'd1, 3'd5, 1'b1, "R10 neg lt");
    chk("R10 lt literal", pred_o, 16'h5555);
    step(rep16(16'h7C00), rep16(16'h7BFF), 16'hFFFF, 2'd1, 3'd2, 1'b1, "R9 inf gt max");
    step(rep64(64'hFFF0_0000_0000_0000), rep64(64'hC000_0000_0000_0000), 16'hFFFF, 2'd3, 3'd6,
         1'b1, "R10 neg inf le");
    chk("R10 le literal", pred_o, 16'h0101);
    // R4: governing bits
    step(rep32(32'h3F80_0000), rep32(32'h3F80_0000), 16'h2222, 2'd2, 3'd0, 1'b1, "R4 non-low gov");
    chk("R4 literal", pred_o, 16'h0000);
    step(rep32(32'h3F80_0000), rep32(32'h3F80_0000), 16'h0101, 2'd2, 3'd1, 1'b1, "R4 partial gov");
    chk("R4 partial literal", pred_o, 16'h0101);
    // R3: size select
    step(rep64(64'h3FF0_0000_0000_0000), rep64(64'h3FF0_0000_0000_0000), 16'hFFFF, 2'd3, 3'd0,
         1'b1, "R3 double eq");
    chk("R3 double literal", pred_o, 16'h0101);
    step(rep16(16'h3C00), rep16(16'h3C00), 16'hFFFF, 2'd0, 3'd0, 1'b1, "R3 invalid size");
    chk("R3 invalid literal", pred_o, 16'h0000);
    // R6: reserved code
    step(rep16(16'h3C00), rep16(16'h3C00), 16'hFFFF, 2'd1, 3'd4, 1'b1, "R6 ne equal");
    step(rep16(16'h3C00), rep16(16'h3C00), 16'hFFFF, 2'd1, 3'd7, 1'b1, "R6 reserved op");
    chk("R6 literal", pred_o, 16'h0000);

    // R9/R10 mixed lanes with special values
    for (int i = 0; i < 600; i++) begin
      logic [127:0] a, b;
      for (int w = 0; w < 4; w++) begin
        a[w*32 +: 32] = $urandom;
        b[w*32 +: 32] = ($urandom_range(0, 3) == 0) ? a[w*32 +: 32] : $urandom;
      end
      if (i % 7 == 0) b = a ^ {8{16'h8000}};
      step(a, b, 16'($urandom), 2'($urandom), 3'($urandom), 1'($urandom_range(0, 4) != 0),
           "R9 R10 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule